// File: doc/BRIEF.md
# Memory version tag checker

This block sits between a load/store pipeline and a small data memory and enforces pointer version tags. Every 64-byte, 64-byte-aligned memory block owns a 4-bit stored tag. Every pointer carries its own 4-bit tag in address bits 63:60. On each load or store the two tags are compared. A match lets the access reach the data memory. A mismatch stops the access and raises a fault.

The fault takes one of two forms. A precise fault returns trap code 0x1A with the response. A deferred error is recorded in a sticky log that holds the PC of the first offending store. Loads always fault precisely. Stores use the deferred form unless the precise-mode input is set. Checking applies only while both the per-task master enable and the per-page check enable are high.

A separate port writes the stored tag of one block. A tag write issued while the task enable is low is refused with an access fault. A block-initialising write clears the block's tag and its data. Every access answers with a registered response exactly one cycle after the request.

Top module: `vtag_guard`

## Requirements
- R1: After reset every stored tag is 0, the deferred log is empty (defer_pending 0, defer_pc 0) and no response is valid. A checked access whose pointer tag is 0 is then granted, and a load returns 0.
- R2: The pointer tag is address bits 63:60 and the block index is address bits [BLK_IDX_W+5:6], with 8 64-bit words per block selected by bits 5:3. A granted tag write with set_valid changes the stored tag of exactly that one block and leaves a neighbouring block at its old tag.
- R3: The tag comparison is made only when task_en and page_chk_en are both 1. Otherwise the access is granted whatever the tags are, and a store writes its data.
- R4: A checked access whose pointer tag equals the stored tag is granted. A store writes acc_wdata to the addressed word, and a load returns that word on rsp_rdata.
- R5: A checked load whose tags differ gives rsp_precise 1 with rsp_trap 0x1A, whatever precise_mode is.
- R6: A checked store whose tags differ gives rsp_deferred 1 when precise_mode is 0. It gives rsp_precise 1 with rsp_trap 0x1A when precise_mode is 1.
- R7: A tag write with task_en 0 yields set_fault 1 and set_fault_type 0xA one cycle later, and the stored tag is left unchanged.
- R8: An init_valid request clears the stored tag of the addressed block to 0 and sets all 8 of its data words to 0.
- R9: A deferred error sets defer_pending and captures acc_pc into defer_pc only if no error is pending. Later deferred errors leave defer_pc unchanged. defer_clear empties the log. A deferred error in the same cycle as defer_clear is captured as a new first error.
- R10: A tag write and an access to the same block in the same cycle are resolved tag write first, so the access is checked against the new tag.
- R11: A faulting access does not write the data memory, and rsp_rdata is 0 with the fault.
- R12: Each request answers one cycle later with rsp_valid 1 and exactly one of rsp_grant, rsp_precise and rsp_deferred set. rsp_trap is 0 unless rsp_precise is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| task_en | input | 1 | Per-task master enable for tag checking and tag writes |
| precise_mode | input | 1 | Report store mismatches as precise faults |
| page_chk_en | input | 1 | Check enable of the page being accessed |
| acc_valid | input | 1 | Load/store request |
| acc_store | input | 1 | 1 = store, 0 = load |
| acc_addr | input | 64 | Tagged access address |
| acc_wdata | input | 64 | Store data |
| acc_pc | input | 64 | PC of the requesting instruction |
| set_valid | input | 1 | Tag write request |
| set_addr | input | 64 | Address of the block whose tag is written |
| set_tag | input | 4 | New stored tag |
| init_valid | input | 1 | Block-initialising write request |
| init_addr | input | 64 | Address of the block to clear |
| defer_clear | input | 1 | Empties the deferred error log |
| rsp_valid | output | 1 | Access response valid |
| rsp_grant | output | 1 | Access granted |
| rsp_precise | output | 1 | Precise tag fault |
| rsp_deferred | output | 1 | Deferred tag error |
| rsp_trap | output | 8 | Trap code, 0x1A with a precise fault |
| rsp_rdata | output | 64 | Load data, 0 on a fault |
| set_fault | output | 1 | Tag write refused |
| set_fault_type | output | 4 | Fault type of a refused tag write, 0xA |
| defer_pending | output | 1 | A deferred error is logged |
| defer_pc | output | 64 | PC of the first logged deferred error |

## Verification
A wrong stored tag does not show until the block is accessed. It then appears as a grant where a fault was due, or the reverse, one cycle after the request. For this reason each tag write is followed by accesses with the matching and the mismatching pointer tag, and also by an access to the neighbouring block. A damaged data word or a store that leaked through on a fault appears only on a later matching load, so every fault scenario ends with such a load. A faulty sticky log shows up the cycle after a second deferred error, as a changed defer_pc.

// File: rtl/vtag_pkg.sv
package vtag_pkg;

    localparam int ADDR_W       = 64;
    localparam int DATA_W       = 64;
    localparam int TAG_W        = 4;
    localparam int TAG_LSB      = 60;
    localparam int BLK_OFF_W    = 6;
    localparam int WORD_LSB     = 3;
    localparam int WORDS_PER_W  = BLK_OFF_W - WORD_LSB;
    localparam int WORDS_PER    = 1 << WORDS_PER_W;

    localparam logic [7:0] TRAP_TAG_MISMATCH = 8'h1A;
    localparam logic [3:0] FAULT_NO_TAGGING  = 4'hA;

    typedef logic [TAG_W-1:0] vtag_t;

    typedef enum logic [1:0] {
        VERDICT_PASS    = 2'd0,
        VERDICT_PRECISE = 2'd1,
        VERDICT_DEFER   = 2'd2
    } verdict_e;

    typedef struct packed {
        logic              valid;
        logic              grant;
        logic              precise;
        logic              deferred;
        logic [7:0]        trap;
        logic [DATA_W-1:0] rdata;
    } acc_rsp_t;

    function automatic vtag_t ptr_tag(input logic [ADDR_W-1:0] a);
        return a[TAG_LSB +: TAG_W];
    endfunction

    function automatic logic [WORDS_PER_W-1:0] word_sel(input logic [ADDR_W-1:0] a);
        return a[WORD_LSB +: WORDS_PER_W];
    endfunction

endpackage

// File: rtl/vtag_store.sv
module vtag_store
    import vtag_pkg::*;
#(
    parameter int BLK_IDX_W = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 set_we,
    input  logic [BLK_IDX_W-1:0] set_blk,
    input  vtag_t                set_tag,
    input  logic                 clr_we,
    input  logic [BLK_IDX_W-1:0] clr_blk,
    input  logic [BLK_IDX_W-1:0] rd_blk,
    output vtag_t                rd_tag
);
    localparam int NBLK = 1 << BLK_IDX_W;

    vtag_t tag_all [NBLK];

    for (genvar g = 0; g < NBLK; g++) begin : g_entry
        vtag_t q;
        always_ff @(posedge clk) begin
            if (rst) begin
                q <= '0;
            end else if (set_we && set_blk == BLK_IDX_W'(g)) begin
                q <= set_tag;
            end else if (clr_we && clr_blk == BLK_IDX_W'(g)) begin
                q <= '0;
            end
        end
        assign tag_all[g] = q;
    end

    // Same-cycle writes are visible to the reader; a tag write beats a clear.
    always_comb begin
        rd_tag = tag_all[rd_blk];
        if (clr_we && clr_blk == rd_blk) begin
            rd_tag = '0;
        end
        if (set_we && set_blk == rd_blk) begin
            rd_tag = set_tag;
        end
    end

endmodule

// File: rtl/vtag_dmem.sv
module vtag_dmem
    import vtag_pkg::*;
#(
    parameter int BLK_IDX_W = 4
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          wr_en,
    input  logic [BLK_IDX_W+WORDS_PER_W-1:0] wr_idx,
    input  logic [DATA_W-1:0]             wr_data,
    input  logic                          clr_en,
    input  logic [BLK_IDX_W-1:0]          clr_blk,
    input  logic [BLK_IDX_W+WORDS_PER_W-1:0] rd_idx,
    output logic [DATA_W-1:0]             rd_data
);
    localparam int IDX_W  = BLK_IDX_W + WORDS_PER_W;
    localparam int NWORDS = 1 << IDX_W;

    logic [DATA_W-1:0] word_all [NWORDS];

    for (genvar w = 0; w < NWORDS; w++) begin : g_word
        logic [DATA_W-1:0] q;
        logic              hit_wr;
        logic              hit_clr;
        assign hit_wr  = wr_en && wr_idx == IDX_W'(w);
        assign hit_clr = clr_en && clr_blk == BLK_IDX_W'(w >> WORDS_PER_W);
        always_ff @(posedge clk) begin
            if (rst) begin
                q <= '0;
            end else if (hit_wr) begin
                q <= wr_data;
            end else if (hit_clr) begin
                q <= '0;
            end
        end
        assign word_all[w] = q;
    end

    assign rd_data = word_all[rd_idx];

endmodule

// File: rtl/vtag_judge.sv
module vtag_judge
    import vtag_pkg::*;
(
    input  logic     is_store,
    input  logic     task_en,
    input  logic     page_en,
    input  logic     precise_mode,
    input  vtag_t    ptr,
    input  vtag_t    stored,
    output verdict_e verdict
);
    logic checked;
    logic differ;

    assign checked = task_en && page_en;
    assign differ  = ptr != stored;

    always_comb begin
        verdict = VERDICT_PASS;
        if (checked && differ) begin
            if (is_store && !precise_mode) begin
                verdict = VERDICT_DEFER;
            end else begin
                verdict = VERDICT_PRECISE;
            end
        end
    end

endmodule

// File: rtl/vtag_defer_log.sv
module vtag_defer_log
    import vtag_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              err_valid,
    input  logic [ADDR_W-1:0] err_pc,
    input  logic              sw_clear,
    output logic              pending,
    output logic [ADDR_W-1:0] first_pc
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pending  <= 1'b0;
            first_pc <= '0;
        end else if (err_valid && (!pending || sw_clear)) begin
            pending  <= 1'b1;
            first_pc <= err_pc;
        end else if (sw_clear) begin
            pending  <= 1'b0;
            first_pc <= '0;
        end
    end

endmodule

// File: rtl/vtag_guard.sv
module vtag_guard
    import vtag_pkg::*;
#(
    parameter int BLK_IDX_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              task_en,
    input  logic              precise_mode,
    input  logic              page_chk_en,
    input  logic              acc_valid,
    input  logic              acc_store,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [DATA_W-1:0] acc_wdata,
    input  logic [ADDR_W-1:0] acc_pc,
    input  logic              set_valid,
    input  logic [ADDR_W-1:0] set_addr,
    input  logic [TAG_W-1:0]  set_tag,
    input  logic              init_valid,
    input  logic [ADDR_W-1:0] init_addr,
    input  logic              defer_clear,
    output logic              rsp_valid,
    output logic              rsp_grant,
    output logic              rsp_precise,
    output logic              rsp_deferred,
    output logic [7:0]        rsp_trap,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              set_fault,
    output logic [3:0]        set_fault_type,
    output logic              defer_pending,
    output logic [ADDR_W-1:0] defer_pc
);
    localparam int IDX_W = BLK_IDX_W + WORDS_PER_W;

    logic [BLK_IDX_W-1:0] acc_blk, set_blk, init_blk;
    logic [IDX_W-1:0]     acc_idx;
    logic                 set_we;
    vtag_t                stored_tag;
    verdict_e             verdict;
    logic [DATA_W-1:0]    mem_rdata;
    logic                 mem_we;
    acc_rsp_t             rsp_q, rsp_d;
    logic                 set_fault_q;

    assign acc_blk  = acc_addr[BLK_OFF_W +: BLK_IDX_W];
    assign set_blk  = set_addr[BLK_OFF_W +: BLK_IDX_W];
    assign init_blk = init_addr[BLK_OFF_W +: BLK_IDX_W];
    assign acc_idx  = {acc_blk, word_sel(acc_addr)};
    assign set_we   = set_valid && task_en;

    logic unused_addr_bits;
    assign unused_addr_bits = ^{acc_addr[TAG_LSB-1:BLK_OFF_W+BLK_IDX_W], acc_addr[WORD_LSB-1:0],
                                set_addr[ADDR_W-1:BLK_OFF_W+BLK_IDX_W], set_addr[BLK_OFF_W-1:0],
                                init_addr[ADDR_W-1:BLK_OFF_W+BLK_IDX_W], init_addr[BLK_OFF_W-1:0]};

    vtag_store #(.BLK_IDX_W(BLK_IDX_W)) u_store (
        .clk     (clk),
        .rst     (rst),
        .set_we  (set_we),
        .set_blk (set_blk),
        .set_tag (set_tag),
        .clr_we  (init_valid),
        .clr_blk (init_blk),
        .rd_blk  (acc_blk),
        .rd_tag  (stored_tag)
    );

    vtag_judge u_judge (
        .is_store     (acc_store),
        .task_en      (task_en),
        .page_en      (page_chk_en),
        .precise_mode (precise_mode),
        .ptr          (ptr_tag(acc_addr)),
        .stored       (stored_tag),
        .verdict      (verdict)
    );

    assign mem_we = acc_valid && acc_store && verdict == VERDICT_PASS;

    vtag_dmem #(.BLK_IDX_W(BLK_IDX_W)) u_dmem (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (mem_we),
        .wr_idx  (acc_idx),
        .wr_data (acc_wdata),
        .clr_en  (init_valid),
        .clr_blk (init_blk),
        .rd_idx  (acc_idx),
        .rd_data (mem_rdata)
    );

    vtag_defer_log u_log (
        .clk       (clk),
        .rst       (rst),
        .err_valid (acc_valid && verdict == VERDICT_DEFER),
        .err_pc    (acc_pc),
        .sw_clear  (defer_clear),
        .pending   (defer_pending),
        .first_pc  (defer_pc)
    );

    always_comb begin
        rsp_d          = '0;
        rsp_d.valid    = acc_valid;
        if (acc_valid) begin
            unique case (verdict)
                VERDICT_PASS: begin
                    rsp_d.grant = 1'b1;
                    rsp_d.rdata = acc_store ? '0 : mem_rdata;
                end
                VERDICT_PRECISE: begin
                    rsp_d.precise = 1'b1;
                    rsp_d.trap    = TRAP_TAG_MISMATCH;
                end
                VERDICT_DEFER: begin
                    rsp_d.deferred = 1'b1;
                end
                default: rsp_d = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_q       <= '0;
            set_fault_q <= 1'b0;
        end else begin
            rsp_q       <= rsp_d;
            set_fault_q <= set_valid && !task_en;
        end
    end

    assign rsp_valid      = rsp_q.valid;
    assign rsp_grant      = rsp_q.grant;
    assign rsp_precise    = rsp_q.precise;
    assign rsp_deferred   = rsp_q.deferred;
    assign rsp_trap       = rsp_q.trap;
    assign rsp_rdata      = rsp_q.rdata;
    assign set_fault      = set_fault_q;
    assign set_fault_type = set_fault_q ? FAULT_NO_TAGGING : 4'h0;

endmodule

// File: rtl/vtag_guard_chk.sv
module vtag_guard_chk (
    input logic        clk,
    input logic        rst,
    input logic        task_en,
    input logic        page_chk_en,
    input logic        acc_valid,
    input logic        acc_store,
    input logic        set_valid,
    input logic        defer_clear,
    input logic        rsp_valid,
    input logic        rsp_grant,
    input logic        rsp_precise,
    input logic        rsp_deferred,
    input logic [7:0]  rsp_trap,
    input logic [63:0] rsp_rdata,
    input logic        set_fault,
    input logic [3:0]  set_fault_type,
    input logic        defer_pending,
    input logic [63:0] defer_pc
);
    p_one_outcome_r12: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $countones({rsp_grant, rsp_precise, rsp_deferred}) == 1);

    p_rsp_follows_r12: assert property (@(posedge clk) disable iff (rst)
        acc_valid |=> rsp_valid);

    p_no_rsp_idle_r12: assert property (@(posedge clk) disable iff (rst)
        !acc_valid |=> !rsp_valid);

    p_load_precise_r5: assert property (@(posedge clk) disable iff (rst)
        acc_valid && !acc_store |=> rsp_grant || rsp_precise);

    p_unchecked_grant_r3: assert property (@(posedge clk) disable iff (rst)
        acc_valid && !(task_en && page_chk_en) |=> rsp_grant);

    p_trap_code_r6: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && rsp_precise |-> rsp_trap == 8'h1A);

    p_fault_no_data_r11: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && !rsp_grant |-> rsp_rdata == 64'd0);

    p_sticky_pc_r9: assert property (@(posedge clk) disable iff (rst)
        defer_pending && !defer_clear |=> defer_pending && $stable(defer_pc));

    p_deferred_logged_r9: assert property (@(posedge clk) disable iff (rst)
        rsp_deferred |-> defer_pending);

    p_set_reject_r7: assert property (@(posedge clk) disable iff (rst)
        set_valid && !task_en |=> set_fault && set_fault_type == 4'hA);

endmodule

bind vtag_guard vtag_guard_chk u_chk (
    .clk            (clk),
    .rst            (rst),
    .task_en        (task_en),
    .page_chk_en    (page_chk_en),
    .acc_valid      (acc_valid),
    .acc_store      (acc_store),
    .set_valid      (set_valid),
    .defer_clear    (defer_clear),
    .rsp_valid      (rsp_valid),
    .rsp_grant      (rsp_grant),
    .rsp_precise    (rsp_precise),
    .rsp_deferred   (rsp_deferred),
    .rsp_trap       (rsp_trap),
    .rsp_rdata      (rsp_rdata),
    .set_fault      (set_fault),
    .set_fault_type (set_fault_type),
    .defer_pending  (defer_pending),
    .defer_pc       (defer_pc)
);

// File: tb/sim_vtag_guard.sv
module sim_vtag_guard;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        task_en, precise_mode, page_chk_en;
    logic        acc_valid, acc_store;
    logic [63:0] acc_addr, acc_wdata, acc_pc;
    logic        set_valid;
    logic [63:0] set_addr;
    logic [3:0]  set_tag;
    logic        init_valid;
    logic [63:0] init_addr;
    logic        defer_clear;
    logic        rsp_valid, rsp_grant, rsp_precise, rsp_deferred;
    logic [7:0]  rsp_trap;
    logic [63:0] rsp_rdata;
    logic        set_fault;
    logic [3:0]  set_fault_type;
    logic        defer_pending;
    logic [63:0] defer_pc;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vtag_guard u0 (
        .clk(clk), .rst(rst), .task_en(task_en), .precise_mode(precise_mode),
        .page_chk_en(page_chk_en), .acc_valid(acc_valid), .acc_store(acc_store),
        .acc_addr(acc_addr), .acc_wdata(acc_wdata), .acc_pc(acc_pc),
        .set_valid(set_valid), .set_addr(set_addr), .set_tag(set_tag),
        .init_valid(init_valid), .init_addr(init_addr), .defer_clear(defer_clear),
        .rsp_valid(rsp_valid), .rsp_grant(rsp_grant), .rsp_precise(rsp_precise),
        .rsp_deferred(rsp_deferred), .rsp_trap(rsp_trap), .rsp_rdata(rsp_rdata),
        .set_fault(set_fault), .set_fault_type(set_fault_type),
        .defer_pending(defer_pending), .defer_pc(defer_pc)
    );

    // tag in 63:60, block in 9:6, word in 5:3
    function automatic logic [63:0] mk(input logic [3:0] tag, input logic [3:0] blk,
                                       input logic [2:0] word);
        return {tag, 50'd0, blk, word, 3'b000};
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Issue one access; results are sampled on the next falling edge.
    task automatic do_acc(input logic st, input logic [63:0] a,
                          input logic [63:0] d, input logic [63:0] pc);
        @(negedge clk);
        acc_valid = 1'b1; acc_store = st; acc_addr = a; acc_wdata = d; acc_pc = pc;
        @(negedge clk);
        acc_valid = 1'b0; acc_store = 1'b0;
    endtask

    task automatic do_set(input logic [63:0] a, input logic [3:0] t);
        @(negedge clk);
        set_valid = 1'b1; set_addr = a; set_tag = t;
        @(negedge clk);
        set_valid = 1'b0;
    endtask

    task automatic t_reset;
        chk("R1", "rsp_valid", 64'(rsp_valid), 64'd0);
        chk("R1", "defer_pending", 64'(defer_pending), 64'd0);
        chk("R1", "defer_pc", defer_pc, 64'd0);
        do_acc(1'b0, mk(4'h0, 4'd3, 3'd1), 64'd0, 64'h100);
        chk("R1", "untagged grant", 64'(rsp_grant), 64'd1);
        chk("R1", "rdata zero", rsp_rdata, 64'd0);
    endtask

    task automatic t_match;
        do_set(mk(4'h0, 4'd5, 3'd0), 4'hA);
        chk("R7", "no set fault when enabled", 64'(set_fault), 64'd0);
        do_acc(1'b1, mk(4'hA, 4'd5, 3'd2), 64'hDEAD_BEEF_0000_0001, 64'h200);
        chk("R4", "store grant", 64'(rsp_grant), 64'd1);
        chk("R12", "valid", 64'(rsp_valid), 64'd1);
        do_acc(1'b0, mk(4'hA, 4'd5, 3'd2), 64'd0, 64'h204);
        chk("R4", "load grant", 64'(rsp_grant), 64'd1);
        chk("R4", "load data", rsp_rdata, 64'hDEAD_BEEF_0000_0001);
        do_acc(1'b0, mk(4'h0, 4'd6, 3'd2), 64'd0, 64'h208);
        chk("R2", "neighbour block keeps tag 0", 64'(rsp_grant), 64'd1);
        do_acc(1'b0, mk(4'hA, 4'd6, 3'd2), 64'd0, 64'h20C);
        chk("R2", "neighbour block rejects tag A", 64'(rsp_precise), 64'd1);
    endtask

    task automatic t_load_mismatch;
        for (int m = 0; m < 2; m++) begin
            precise_mode = m[0];
            do_acc(1'b0, mk(4'h3, 4'd5, 3'd2), 64'd0, 64'h300);
            chk("R5", "load precise", 64'(rsp_precise), 64'd1);
            chk("R5", "trap code", 64'(rsp_trap), 64'h1A);
            chk("R11", "load fault rdata", rsp_rdata, 64'd0);
            chk("R12", "no grant", 64'(rsp_grant), 64'd0);
        end
        precise_mode = 1'b0;
    endtask

    task automatic t_store_mismatch;
        do_acc(1'b1, mk(4'h3, 4'd5, 3'd2), 64'h1111, 64'h400);
        chk("R6", "store deferred", 64'(rsp_deferred), 64'd1);
        chk("R12", "trap zero on deferred", 64'(rsp_trap), 64'd0);
        chk("R9", "pending", 64'(defer_pending), 64'd1);
        chk("R9", "first pc", defer_pc, 64'h400);
        do_acc(1'b1, mk(4'h4, 4'd5, 3'd2), 64'h2222, 64'h480);
        chk("R6", "second deferred", 64'(rsp_deferred), 64'd1);
        chk("R9", "pc kept", defer_pc, 64'h400);
        precise_mode = 1'b1;
        do_acc(1'b1, mk(4'h3, 4'd5, 3'd2), 64'h3333, 64'h500);
        chk("R6", "store precise", 64'(rsp_precise), 64'd1);
        chk("R6", "store trap", 64'(rsp_trap), 64'h1A);
        precise_mode = 1'b0;
        do_acc(1'b0, mk(4'hA, 4'd5, 3'd2), 64'd0, 64'h504);
        chk("R11", "data not written by faults", rsp_rdata, 64'hDEAD_BEEF_0000_0001);
        @(negedge clk); defer_clear = 1'b1;
        @(negedge clk); defer_clear = 1'b0;
        chk("R9", "cleared pending", 64'(defer_pending), 64'd0);
        chk("R9", "cleared pc", defer_pc, 64'd0);
    endtask

    task automatic t_gate;
        task_en = 1'b0;
        do_acc(1'b0, mk(4'h7, 4'd5, 3'd2), 64'd0, 64'h600);
        chk("R3", "task off grant", 64'(rsp_grant), 64'd1);
        do_acc(1'b1, mk(4'h7, 4'd5, 3'd3), 64'h5555, 64'h604);
        chk("R3", "task off store grant", 64'(rsp_grant), 64'd1);
        task_en = 1'b1; page_chk_en = 1'b0;
        do_acc(1'b0, mk(4'h7, 4'd5, 3'd3), 64'd0, 64'h608);
        chk("R3", "page off grant", 64'(rsp_grant), 64'd1);
        chk("R3", "unchecked store landed", rsp_rdata, 64'h5555);
        page_chk_en = 1'b1;
    endtask

    task automatic t_set_reject;
        task_en = 1'b0;
        do_set(mk(4'h0, 4'd5, 3'd0), 4'h7);
        chk("R7", "set fault", 64'(set_fault), 64'd1);
        chk("R7", "fault type", 64'(set_fault_type), 64'hA);
        task_en = 1'b1;
        do_acc(1'b0, mk(4'hA, 4'd5, 3'd2), 64'd0, 64'h700);
        chk("R7", "old tag still matches", 64'(rsp_grant), 64'd1);
        do_acc(1'b0, mk(4'h7, 4'd5, 3'd2), 64'd0, 64'h704);
        chk("R7", "refused tag not stored", 64'(rsp_precise), 64'd1);
    endtask

    task automatic t_init;
        @(negedge clk); init_valid = 1'b1; init_addr = mk(4'h0, 4'd5, 3'd0);
        @(negedge clk); init_valid = 1'b0;
        do_acc(1'b0, mk(4'h0, 4'd5, 3'd2), 64'd0, 64'h800);
        chk("R8", "tag cleared", 64'(rsp_grant), 64'd1);
        chk("R8", "data cleared", rsp_rdata, 64'd0);
        do_acc(1'b0, mk(4'h0, 4'd5, 3'd3), 64'd0, 64'h804);
        chk("R8", "other word cleared", rsp_rdata, 64'd0);
        do_acc(1'b0, mk(4'hA, 4'd5, 3'd2), 64'd0, 64'h808);
        chk("R8", "old tag gone", 64'(rsp_precise), 64'd1);
    endtask

    task automatic t_bypass;
        @(negedge clk);
        set_valid = 1'b1; set_addr = mk(4'h0, 4'd9, 3'd0); set_tag = 4'h6;
        acc_valid = 1'b1; acc_store = 1'b0; acc_addr = mk(4'h6, 4'd9, 3'd0); acc_pc = 64'h900;
        @(negedge clk);
        set_valid = 1'b0; acc_valid = 1'b0;
        chk("R10", "checked against new tag", 64'(rsp_grant), 64'd1);
        do_acc(1'b0, mk(4'h0, 4'd9, 3'd0), 64'd0, 64'h904);
        chk("R10", "new tag kept", 64'(rsp_precise), 64'd1);
    endtask

    task automatic t_clear_race;
        do_acc(1'b1, mk(4'h1, 4'd9, 3'd1), 64'h77, 64'hA00);
        chk("R9", "first logged", defer_pc, 64'hA00);
        @(negedge clk);
        defer_clear = 1'b1;
        acc_valid = 1'b1; acc_store = 1'b1; acc_addr = mk(4'h2, 4'd9, 3'd1);
        acc_wdata = 64'h88; acc_pc = 64'hB00;
        @(negedge clk);
        defer_clear = 1'b0; acc_valid = 1'b0;
        chk("R9", "race pending", 64'(defer_pending), 64'd1);
        chk("R9", "race new pc", defer_pc, 64'hB00);
    endtask

    initial begin
        rst = 1'b1; task_en = 1'b1; precise_mode = 1'b0; page_chk_en = 1'b1;
        acc_valid = 1'b0; acc_store = 1'b0; acc_addr = '0; acc_wdata = '0; acc_pc = '0;
        set_valid = 1'b0; set_addr = '0; set_tag = '0;
        init_valid = 1'b0; init_addr = '0; defer_clear = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_match();
        t_load_mismatch();
        t_store_mismatch();
        t_gate();
        t_set_reject();
        t_init();
        t_bypass();
        t_clear_race();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog run did not complete");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule